// File: doc/BRIEF.md
# Core Idle State Sequencer

This block walks a single processor core down from the running state into one of three idle levels and back up again. Software issues a one-cycle request that carries the target depth. Level 1 is halt: the pipeline is stalled and the main core clocks are gated, but snoops are still answered. Level 2 is clock-stop: the remaining core clocks are gated and snooping is turned off, after the core caches have been flushed. Level 3 is power-off: the core power switch opens after the architectural state has been saved.

Each deeper level adds its own shutdown steps on top of the shallower ones. A wake event undoes those steps in strict reverse order. When a wake arrives part way through an entry, only the steps already taken are undone. The flush engine, the save/restore storage and the power switch are outside the block and are reached through request/acknowledge pairs. The block reports the level the core currently sits at and a wake-latency class. The latency class is the deepest level reached in the current idle episode, and it is held until the core is running again.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core is active: state_o=0, lat_class_o=0, stall_o=0, both clock enables 1, snoop_en_o=1, and flush_req_o, save_req_o, pwr_off_o and restore_req_o are all 0.
- R2: An accepted request moves the core to halt on the next cycle: stall_o=1, clk_main_en_o=0, clk_rest_en_o=1, snoop_en_o=1, state_o=1. A request is accepted when the core is active, req_valid_i=1, req_depth_i is 1, 2 or 3, and wake_i=0.
- R3: For depth 2 or 3, flush_req_o rises one cycle after halt is reached and stays high until flush_ack_i. On the cycle after the acknowledge, clk_rest_en_o=0, snoop_en_o=0, flush_req_o=0 and state_o=2.
- R4: For depth 3, save_req_o rises one cycle after clock-stop is reached and stays high until save_ack_i. On the cycle after the acknowledge, pwr_off_o=1, save_req_o=0 and state_o=3.
- R5: Wake from power-off runs these steps, one per cycle unless noted: pwr_off_o=0 for PG_DELAY cycles; then restore_req_o=1 until restore_ack_i; then clk_rest_en_o=1 with snoop_en_o=1; then clk_main_en_o=1; then stall_o=0. state_o reads 3 until the restore finishes and 1 during the two clock steps.
- R6: Wake from clock-stop enables the remaining clocks and snooping, then the main clocks, then releases the stall, one cycle each. Wake from halt enables the main clocks, then releases the stall.
- R7: A wake during the flush wait drops flush_req_o on the next cycle and unwinds halt only. A wake during the save wait drops save_req_o and unwinds clock-stop, then halt.
- R8: lat_class_o equals the deepest level (1, 2 or 3) reached in the current episode. It is held through the whole exit and returns to 0 when the core is active.
- R9: The following have no effect and leave the core active: a request for depth 0 or depth 4 or above, a request that coincides with wake_i, and a wake_i while active. A request made while the core is not active is also ignored, and so is a wake_i during an exit.
- R10: When wake_i and flush_ack_i or save_ack_i arrive in the same cycle, the wake wins and the deeper step is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Idle request strobe |
| req_depth_i | input | DEPTH_W | Requested idle depth |
| wake_i | input | 1 | Wake event |
| flush_ack_i | input | 1 | Cache flush done |
| save_ack_i | input | 1 | State save done |
| restore_ack_i | input | 1 | State restore done |
| stall_o | output | 1 | Pipeline stall |
| clk_main_en_o | output | 1 | Enable for the main core clocks |
| clk_rest_en_o | output | 1 | Enable for the remaining core clocks |
| snoop_en_o | output | 1 | Snoop responses enabled |
| flush_req_o | output | 1 | Cache flush request |
| save_req_o | output | 1 | State save request |
| pwr_off_o | output | 1 | Core power switch open |
| restore_req_o | output | 1 | State restore request |
| state_o | output | 2 | Current level, 0 to 3 |
| lat_class_o | output | 2 | Wake-latency class |

## Verification
The bench builds the block with DEPTH_W=3 so that the unsupported depths 4 to 7 can be driven at the port. It uses PG_DELAY=3, which keeps every power-up wait short enough to fit many full power-off round trips into the run. With these values the bench reaches all three exit paths, aborts at both handshake waits, wakes that collide with acknowledges, and every class of ignored request, with a multi-cycle power-good count in each power-off exit.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [3:0] {
    S_ACT, S_HALT, S_FLUSH, S_CSTOP, S_SAVE, S_PGATE,
    S_XPWR, S_XRST, S_XCLKR, S_XCLKM
  } cis_st_e;

  localparam logic [1:0] LVL_ACT  = 2'd0;
  localparam logic [1:0] LVL_HALT = 2'd1;
  localparam logic [1:0] LVL_CSTP = 2'd2;
  localparam logic [1:0] LVL_POFF = 2'd3;
endpackage

// File: rtl/cis_delay.sv
module cis_delay #(
  parameter int unsigned PG_DELAY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(PG_DELAY + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(PG_DELAY - 1));
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
  import cis_pkg::*;
#(
  parameter int unsigned DEPTH_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [DEPTH_W-1:0] req_depth_i,
  input  logic               wake_i,
  input  logic               flush_ack_i,
  input  logic               save_ack_i,
  input  logic               restore_ack_i,
  input  logic               dly_done_i,
  output cis_st_e            st_o,
  output logic [1:0]         lat_o
);
  cis_st_e    st_q, st_d;
  logic [1:0] tgt_q, lat_q, lat_d;
  logic       depth_ok, take;

  assign depth_ok = (req_depth_i != '0) && (req_depth_i <= DEPTH_W'(3));
  assign take     = (st_q == S_ACT) && req_valid_i && depth_ok && !wake_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_ACT:   if (take) st_d = S_HALT;
      S_HALT:  if (wake_i) st_d = S_XCLKM;
               else if (tgt_q >= LVL_CSTP) st_d = S_FLUSH;
      S_FLUSH: if (wake_i) st_d = S_XCLKM;
               else if (flush_ack_i) st_d = S_CSTOP;
      S_CSTOP: if (wake_i) st_d = S_XCLKR;
               else if (tgt_q == LVL_POFF) st_d = S_SAVE;
      S_SAVE:  if (wake_i) st_d = S_XCLKR;
               else if (save_ack_i) st_d = S_PGATE;
      S_PGATE: if (wake_i) st_d = S_XPWR;
      S_XPWR:  if (dly_done_i) st_d = S_XRST;
      S_XRST:  if (restore_ack_i) st_d = S_XCLKR;
      S_XCLKR: st_d = S_XCLKM;
      S_XCLKM: st_d = S_ACT;
      default: st_d = S_ACT;
    endcase
  end

  // latency class follows the deepest level entered, held through exit
  always_comb begin
    lat_d = lat_q;
    case (st_d)
      S_ACT:   lat_d = LVL_ACT;
      S_HALT:  lat_d = LVL_HALT;
      S_CSTOP: lat_d = LVL_CSTP;
      S_PGATE: lat_d = LVL_POFF;
      default: lat_d = lat_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_ACT;
      tgt_q <= LVL_ACT;
      lat_q <= LVL_ACT;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      if (take) tgt_q <= req_depth_i[1:0];
    end
  end

  assign st_o  = st_q;
  assign lat_o = lat_q;

  AST_DEEPER_NEEDS_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_CSTOP && $past(st_q) == S_FLUSH) |-> $past(flush_ack_i && !wake_i)); // R3
  AST_WAKE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_SAVE) && wake_i) |=> (st_q == S_XCLKR)); // R10
endmodule

// File: rtl/cis_out_dec.sv
module cis_out_dec
  import cis_pkg::*;
(
  input  cis_st_e    st_i,
  output logic       stall_o,
  output logic       clk_main_en_o,
  output logic       clk_rest_en_o,
  output logic       snoop_en_o,
  output logic       flush_req_o,
  output logic       save_req_o,
  output logic       pwr_off_o,
  output logic       restore_req_o,
  output logic [1:0] level_o
);
  logic deep;
  assign deep = st_i inside {S_CSTOP, S_SAVE, S_PGATE, S_XPWR, S_XRST};

  always_comb begin
    stall_o       = (st_i != S_ACT);
    clk_main_en_o = (st_i == S_ACT) || (st_i == S_XCLKM);
    clk_rest_en_o = !deep;
    snoop_en_o    = !deep;
    flush_req_o   = (st_i == S_FLUSH);
    save_req_o    = (st_i == S_SAVE);
    pwr_off_o     = (st_i == S_PGATE);
    restore_req_o = (st_i == S_XRST);
    unique case (st_i)
      S_ACT:                   level_o = LVL_ACT;
      S_CSTOP, S_SAVE:         level_o = LVL_CSTP;
      S_PGATE, S_XPWR, S_XRST: level_o = LVL_POFF;
      default:                 level_o = LVL_HALT;
    endcase
  end
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cis_pkg::*;
#(
  parameter int unsigned DEPTH_W  = 3,
  parameter int unsigned PG_DELAY = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [DEPTH_W-1:0] req_depth_i,
  input  logic               wake_i,
  input  logic               flush_ack_i,
  input  logic               save_ack_i,
  input  logic               restore_ack_i,
  output logic               stall_o,
  output logic               clk_main_en_o,
  output logic               clk_rest_en_o,
  output logic               snoop_en_o,
  output logic               flush_req_o,
  output logic               save_req_o,
  output logic               pwr_off_o,
  output logic               restore_req_o,
  output logic [1:0]         state_o,
  output logic [1:0]         lat_class_o
);
  cis_st_e st;
  logic    dly_done;

  cis_fsm #(.DEPTH_W(DEPTH_W)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_depth_i, .wake_i,
    .flush_ack_i, .save_ack_i, .restore_ack_i,
    .dly_done_i(dly_done), .st_o(st), .lat_o(lat_class_o)
  );

  cis_delay #(.PG_DELAY(PG_DELAY)) u_dly (
    .clk_i, .rst_ni, .run_i(st == S_XPWR), .done_o(dly_done)
  );

  cis_out_dec u_dec (
    .st_i(st), .stall_o, .clk_main_en_o, .clk_rest_en_o, .snoop_en_o,
    .flush_req_o, .save_req_o, .pwr_off_o, .restore_req_o, .level_o(state_o)
  );

  AST_GATE_AFTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_off_o) |-> $past(save_ack_i)); // R4
  AST_STOP_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_rest_en_o) |-> $past(flush_ack_i)); // R3
  AST_RESTORE_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o |-> (!pwr_off_o && !clk_rest_en_o)); // R5
  AST_STALL_WHEN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_main_en_o |-> stall_o); // R2
  AST_ONE_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({flush_req_o, save_req_o, restore_req_o}) <= 1); // R3
  AST_LAT_COVERS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_class_o >= state_o); // R8
  AST_RELEASE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> $past(clk_main_en_o && clk_rest_en_o)); // R6
endmodule

// File: tb/core_idle_seq_tb_top.sv
module core_idle_seq_tb_top;
  localparam int DW  = 3;
  localparam int PGD = 3;

  localparam int P_ACT = 0, P_HALT = 1, P_FLUSH = 2, P_CSTOP = 3, P_SAVE = 4,
                 P_PGATE = 5, P_XPWR = 6, P_XRST = 7, P_XCLKR = 8, P_XCLKM = 9;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wake = 0, fack = 0, sack = 0, rack = 0;
  logic [DW-1:0] depth = '0;
  logic stall, cme, cre, snp, frq, srq, poff, rrq;
  logic [1:0] lvl, lat;

  int checks = 0, errors = 0, cycles = 0;
  int m = P_ACT, m_tgt = 0, m_lat = 0, m_cnt = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  core_idle_seq #(.DEPTH_W(DW), .PG_DELAY(PGD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_depth_i(depth),
    .wake_i(wake), .flush_ack_i(fack), .save_ack_i(sack), .restore_ack_i(rack),
    .stall_o(stall), .clk_main_en_o(cme), .clk_rest_en_o(cre), .snoop_en_o(snp),
    .flush_req_o(frq), .save_req_o(srq), .pwr_off_o(poff), .restore_req_o(rrq),
    .state_o(lvl), .lat_class_o(lat)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = P_ACT; m_lat = 0; m_tgt = 0; m_cnt = 0;
    end else begin
      case (m)
        P_ACT:   if (req_valid && !wake && depth >= 1 && depth <= 3) begin
                   m = P_HALT; m_tgt = int'(depth); m_lat = 1;
                 end
        P_HALT:  if (wake) m = P_XCLKM; else if (m_tgt >= 2) m = P_FLUSH;
        P_FLUSH: if (wake) m = P_XCLKM; else if (fack) begin m = P_CSTOP; m_lat = 2; end
        P_CSTOP: if (wake) m = P_XCLKR; else if (m_tgt == 3) m = P_SAVE;
        P_SAVE:  if (wake) m = P_XCLKR; else if (sack) begin m = P_PGATE; m_lat = 3; end
        P_PGATE: if (wake) begin m = P_XPWR; m_cnt = 0; end
        P_XPWR:  begin m_cnt++; if (m_cnt == PGD) m = P_XRST; end
        P_XRST:  if (rack) m = P_XCLKR;
        P_XCLKR: m = P_XCLKM;
        default: begin m = P_ACT; m_lat = 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  function automatic int exp_lvl(int s);
    case (s)
      P_ACT: return 0;
      P_CSTOP, P_SAVE: return 2;
      P_PGATE, P_XPWR, P_XRST: return 3;
      default: return 1;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      bit deep;
      deep = (m == P_CSTOP || m == P_SAVE || m == P_PGATE || m == P_XPWR || m == P_XRST);
      chk("R2 stall", stall, m != P_ACT);
      chk("R6 main clock enable", cme, m == P_ACT || m == P_XCLKM);
      chk("R3 rest clock enable", cre, !deep);
      chk("R3 snoop enable", snp, !deep);
      chk("R3 flush request", frq, m == P_FLUSH);
      chk("R4 save request", srq, m == P_SAVE);
      chk("R4 power off", poff, m == P_PGATE);
      chk("R5 restore request", rrq, m == P_XRST);
      chk("R1 state level", lvl, exp_lvl(m));
      chk("R8 latency class", lat, m_lat);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_req(input int d);
    req_valid = 1; depth = DW'(d); step(1); req_valid = 0; depth = '0;
  endtask

  task automatic pulse_wake();
    wake = 1; step(1); wake = 0;
  endtask

  task automatic flush_done();
    fack = 1; step(1); fack = 0;
  endtask

  task automatic save_done();
    sack = 1; step(1); sack = 0;
  endtask

  initial begin
    step(2);
    cmp_on = 1;
    // R1 reset state
    chk("R1 reset level", lvl, 0);
    chk("R1 reset stall", stall, 0);
    rst_n = 1;
    step(2);

    // R2 / R6 halt round trip
    pulse_req(1);
    chk("R2 halt level", lvl, 1);
    step(3);
    pulse_req(3); // R9 request while idle is ignored
    chk("R9 no deepening", lvl, 1);
    pulse_wake();
    chk("R6 main clocks back", cme, 1);
    step(1);
    chk("R6 stall released", stall, 0);

    // R3 / R6 clock-stop round trip
    pulse_req(2);
    step(3);
    chk("R3 flush pending", frq, 1);
    flush_done();
    chk("R3 clock-stop level", lvl, 2);
    step(2);
    pulse_wake();
    chk("R6 rest clocks first", cre, 1);
    step(2);

    // R4 / R5 power-off round trip
    pulse_req(3);
    step(1); flush_done();
    step(2); save_done();
    chk("R4 power gated", poff, 1);
    step(3);
    pulse_wake();
    chk("R5 power restored", poff, 0);
    step(PGD + 2);
    chk("R5 restore waiting", rrq, 1);
    rack = 1; step(1); rack = 0;
    chk("R5 rest clocks after restore", cre, 1);
    chk("R8 class held", lat, 3);
    step(3);

    // R7 abort during flush
    pulse_req(3);
    step(2);
    pulse_wake();
    chk("R7 flush dropped", frq, 0);
    step(2);
    // R7 abort during save
    pulse_req(3);
    step(1); flush_done();
    step(2);
    pulse_wake();
    chk("R7 save dropped", srq, 0);
    step(3);

    // R10 wake with acknowledge in the same cycle
    pulse_req(2);
    step(1);
    fack = 1; wake = 1; step(1); fack = 0; wake = 0;
    chk("R10 flush ack lost to wake", cre, 1);
    step(3);
    pulse_req(3);
    step(1); flush_done(); step(1);
    sack = 1; wake = 1; step(1); sack = 0; wake = 0;
    chk("R10 save ack lost to wake", poff, 0);
    step(3);

    // R9 ignored requests
    pulse_req(0);
    chk("R9 depth zero", lvl, 0);
    for (int d = 4; d < 8; d++) begin
      pulse_req(d);
      chk("R9 unsupported depth", stall, 0);
    end
    req_valid = 1; depth = 3'd2; wake = 1; step(1);
    req_valid = 0; depth = '0; wake = 0;
    chk("R9 request with wake", lvl, 0);
    pulse_wake();
    chk("R9 wake while active", stall, 0);
    // R9 wake during exit ignored
    pulse_req(3); step(1); flush_done(); step(1); save_done();
    pulse_wake(); pulse_wake(); step(PGD);
    rack = 1; step(1); rack = 0;
    step(3);
    chk("R9 back to active", lvl, 0);

    finish_run();
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule